// File: doc/BRIEF.md
# Tagged Response Sink with Tag-Pool Tracker

This block sits on the receive side of a memory controller. It takes response beats from a streaming interface that has no ready signal, so every beat with valid high is taken in the cycle it appears. Start and end markers group the beats into responses. A response may be a single beat, with both markers set in the same cycle, or a run of beats from a start beat to an end beat. Each beat that belongs to an open response is passed to a downstream consumer one cycle later. Each response that closes is summarised downstream for one cycle, carrying its tag, command, error bit and beat count.

The block also keeps the pool of 9-bit request tags as an in-flight bitmap. The request side marks a tag busy through an allocate strobe. A closing response returns its tag to the free pool. The current number of busy tags is always visible. Protocol faults set sticky flags that only reset clears: allocating a tag twice, completing a tag that is not in flight, nesting a start, a stray beat, a gap in valid, a header that changes, and a length that does not match the size field.

Top module: `rsp_sink_top`

## Requirements
- R1: After reset, `err_flags` is 0, `inflight_cnt` is 0, and `done_vld` and `beat_vld` are low.
- R2: An `alloc_vld` strobe with a free `alloc_tag` marks that tag in flight, and `inflight_cnt` rises by one in the next cycle.
- R3: Allocating a tag that is already in flight sets `err_flags[0]` in the next cycle and leaves `inflight_cnt` unchanged.
- R4: A beat with valid, start and end all high is a complete response. One cycle later `done_vld` pulses with that beat's tag, command and error bit and `done_beats` = 1. In the same cycle its tag leaves the in-flight set.
- R5: In a multi-beat response, every beat from start to end appears on `beat_vld`/`beat_data` one cycle after it arrives. `done_vld` pulses only one cycle after the end beat. `done_beats` is the number of beats. `done_err` is the OR of the error bits of all beats. The tag is freed at the end beat.
- R6: A response that completes with a tag not in flight sets `err_flags[1]`. It is still reported on `done_vld`, and `inflight_cnt` is unchanged.
- R7: A start beat while a response is open sets `err_flags[2]`. The open response is dropped without completion and its tag stays in flight. The new beat starts a fresh response.
- R8: A valid beat without a start marker while no response is open sets `err_flags[3]`. It is not forwarded, and it completes nothing.
- R9: Valid going low while a response is open sets `err_flags[4]`. The response is abandoned with no `done_vld`, and its tag stays in flight.
- R10: A tag or command on a later beat that differs from the start beat's sets `err_flags[5]`. The response is reported with the start beat's tag and command.
- R11: The expected beat count is the value of the size field, except that size 0 expects one beat. A completed response whose beat count differs sets `err_flags[6]`.
- R12: An allocate and a completion of the same tag in the same cycle raise no error. The tag ends up in flight, and `inflight_cnt` is unchanged.
- R13: Every `err_flags` bit, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Marks `alloc_tag` in flight |
| alloc_tag | input | 9 | Tag being issued |
| rsp_vld | input | 1 | Response beat present |
| rsp_tag | input | 9 | Response tag |
| rsp_cmd | input | 6 | Response command code |
| rsp_size | input | 3 | Size field giving expected beat count |
| rsp_data | input | 256 | Beat payload |
| rsp_err | input | 1 | Response error bit |
| rsp_sop | input | 1 | First beat of response |
| rsp_eop | input | 1 | Last beat of response |
| beat_vld | output | 1 | Forwarded beat present |
| beat_data | output | 256 | Forwarded payload |
| done_vld | output | 1 | One-cycle completion pulse |
| done_tag | output | 9 | Tag of completed response |
| done_cmd | output | 6 | Command of completed response |
| done_err | output | 1 | Accumulated error bit |
| done_beats | output | 4 | Beats received |
| inflight_cnt | output | 10 | Number of tags in flight |
| err_flags | output | 7 | Sticky protocol fault flags |

## Verification
The hardest case to reach is a collision inside a single cycle: the end of one response and a fresh allocation of the same tag. The stimulus arranges it directly. It allocates a tag and then drives the single-beat completion together with a second allocate strobe for that tag. A later response on the same tag then confirms that the tag really stayed in flight. The abandoned-response cases also need care. A nested start or a valid gap must leave the old tag busy, which the bench observes through `inflight_cnt` after the fault.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int ERR_N        = 7;
    localparam int ERR_DUP      = 0;
    localparam int ERR_UNEXP    = 1;
    localparam int ERR_NEST     = 2;
    localparam int ERR_ORPHAN   = 3;
    localparam int ERR_GAP      = 4;
    localparam int ERR_HDR      = 5;
    localparam int ERR_LEN      = 6;

    typedef enum logic {
        FRM_IDLE = 1'b0,
        FRM_BODY = 1'b1
    } frm_state_e;

endpackage

// File: rtl/rsp_tag_pool.sv
module rsp_tag_pool #(
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_vld,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             free_vld,
    input  logic [TAG_W-1:0] free_tag,
    output logic             dup_alloc,
    output logic             unexp_free,
    output logic [TAG_W:0]   inflight_cnt
);
    localparam int NUM_TAGS = 1 << TAG_W;
    localparam int CNT_W    = TAG_W + 1;

    typedef struct packed {
        logic [NUM_TAGS-1:0] busy;
        logic [CNT_W-1:0]    cnt;
    } pool_s;

    pool_s p_d, p_q;
    logic  do_set, do_clr, same_tag;

    always_comb begin
        p_d        = p_q;
        same_tag   = free_vld && alloc_vld && (free_tag == alloc_tag);
        unexp_free = free_vld && !p_q.busy[free_tag];
        do_clr     = free_vld && p_q.busy[free_tag];
        dup_alloc  = alloc_vld && p_q.busy[alloc_tag] && !same_tag;
        do_set     = alloc_vld && !dup_alloc;
        if (do_clr) begin
            p_d.busy[free_tag] = 1'b0;
        end
        if (do_set) begin
            p_d.busy[alloc_tag] = 1'b1;
        end
        p_d.cnt = p_q.cnt
                + CNT_W'(do_set && !p_q.busy[alloc_tag])
                + CNT_W'(do_set && same_tag && do_clr)
                - CNT_W'(do_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign inflight_cnt = p_q.cnt;

    AST_ALLOC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_vld |=> p_q.busy[$past(alloc_tag)]);                       // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.cnt <= CNT_W'(NUM_TAGS));                                    // R2

    AST_DUP_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (dup_alloc && !free_vld) |=> (p_q.cnt == $past(p_q.cnt)));        // R3

    AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (free_vld && !(alloc_vld && alloc_tag == free_tag))
        |=> !p_q.busy[$past(free_tag)]);                                 // R4

    AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (free_vld && alloc_vld && alloc_tag == free_tag && p_q.busy[free_tag])
        |=> (p_q.cnt == $past(p_q.cnt)));                                // R12

endmodule

// File: rtl/rsp_framer.sv
module rsp_framer
    import rsp_pkg::*;
#(
    parameter int TAG_W  = 9,
    parameter int CMD_W  = 6,
    parameter int SIZE_W = 3,
    parameter int BCNT_W = SIZE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_vld,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [CMD_W-1:0]  rsp_cmd,
    input  logic [SIZE_W-1:0] rsp_size,
    input  logic              rsp_err,
    input  logic              rsp_sop,
    input  logic              rsp_eop,
    output logic              fwd,
    output logic              cmpl,
    output logic [TAG_W-1:0]  cmpl_tag,
    output logic [CMD_W-1:0]  cmpl_cmd,
    output logic              cmpl_err,
    output logic [BCNT_W-1:0] cmpl_beats,
    output logic              e_len,
    output logic              e_nest,
    output logic              e_orphan,
    output logic              e_gap,
    output logic              e_hdr
);
    typedef struct packed {
        frm_state_e        st;
        logic [TAG_W-1:0]  tag;
        logic [CMD_W-1:0]  cmd;
        logic [SIZE_W-1:0] size;
        logic              err;
        logic [BCNT_W-1:0] beats;
    } frm_s;

    frm_s s_d, s_q;

    function automatic logic [BCNT_W-1:0] want_beats(input logic [SIZE_W-1:0] sz);
        return (sz == '0) ? BCNT_W'(1) : BCNT_W'(sz);
    endfunction

    function automatic logic [BCNT_W-1:0] sat_inc(input logic [BCNT_W-1:0] v);
        return (&v) ? v : v + BCNT_W'(1);
    endfunction

    always_comb begin
        s_d        = s_q;
        fwd        = 1'b0;
        cmpl       = 1'b0;
        cmpl_tag   = s_q.tag;
        cmpl_cmd   = s_q.cmd;
        cmpl_err   = s_q.err;
        cmpl_beats = s_q.beats;
        e_len      = 1'b0;
        e_nest     = 1'b0;
        e_orphan   = 1'b0;
        e_gap      = 1'b0;
        e_hdr      = 1'b0;
        if (rsp_vld) begin
            if (rsp_sop) begin
                fwd    = 1'b1;
                e_nest = (s_q.st == FRM_BODY);
                if (rsp_eop) begin
                    cmpl       = 1'b1;
                    cmpl_tag   = rsp_tag;
                    cmpl_cmd   = rsp_cmd;
                    cmpl_err   = rsp_err;
                    cmpl_beats = BCNT_W'(1);
                    e_len      = (want_beats(rsp_size) != BCNT_W'(1));
                    s_d.st     = FRM_IDLE;
                end else begin
                    s_d.st    = FRM_BODY;
                    s_d.tag   = rsp_tag;
                    s_d.cmd   = rsp_cmd;
                    s_d.size  = rsp_size;
                    s_d.err   = rsp_err;
                    s_d.beats = BCNT_W'(1);
                end
            end else if (s_q.st == FRM_BODY) begin
                fwd       = 1'b1;
                e_hdr     = (rsp_tag != s_q.tag) || (rsp_cmd != s_q.cmd);
                s_d.beats = sat_inc(s_q.beats);
                s_d.err   = s_q.err | rsp_err;
                if (rsp_eop) begin
                    cmpl       = 1'b1;
                    cmpl_err   = s_d.err;
                    cmpl_beats = s_d.beats;
                    e_len      = (s_d.beats != want_beats(s_q.size));
                    s_d.st     = FRM_IDLE;
                end
            end else begin
                e_orphan = 1'b1;
            end
        end else if (s_q.st == FRM_BODY) begin
            e_gap  = 1'b1;
            s_d.st = FRM_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_OPEN_HAS_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == FRM_BODY) |-> (s_q.beats != '0));                     // R5

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_sop && !rsp_eop)
        |=> (s_q.st == FRM_BODY && s_q.tag == $past(rsp_tag)));          // R7

    AST_GAP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |=> (s_q.st == FRM_IDLE));                              // R9

    AST_HDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == FRM_BODY && rsp_vld && !rsp_sop)
        |=> (s_q.tag == $past(s_q.tag) && s_q.cmd == $past(s_q.cmd)));   // R10

endmodule

// File: rtl/rsp_sink_top.sv
module rsp_sink_top
    import rsp_pkg::*;
#(
    parameter int TAG_W  = 9,
    parameter int CMD_W  = 6,
    parameter int SIZE_W = 3,
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_vld,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              rsp_vld,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [CMD_W-1:0]  rsp_cmd,
    input  logic [SIZE_W-1:0] rsp_size,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rsp_err,
    input  logic              rsp_sop,
    input  logic              rsp_eop,
    output logic              beat_vld,
    output logic [DATA_W-1:0] beat_data,
    output logic              done_vld,
    output logic [TAG_W-1:0]  done_tag,
    output logic [CMD_W-1:0]  done_cmd,
    output logic              done_err,
    output logic [SIZE_W:0]   done_beats,
    output logic [TAG_W:0]    inflight_cnt,
    output logic [ERR_N-1:0]  err_flags
);
    localparam int BCNT_W = SIZE_W + 1;

    typedef struct packed {
        logic              beat_vld;
        logic [DATA_W-1:0] beat_data;
        logic              done_vld;
        logic [TAG_W-1:0]  done_tag;
        logic [CMD_W-1:0]  done_cmd;
        logic              done_err;
        logic [BCNT_W-1:0] done_beats;
        logic [ERR_N-1:0]  err;
    } out_s;

    out_s o_d, o_q;

    logic              fwd, cmpl, cmpl_err;
    logic [TAG_W-1:0]  cmpl_tag;
    logic [CMD_W-1:0]  cmpl_cmd;
    logic [BCNT_W-1:0] cmpl_beats;
    logic              e_len, e_nest, e_orphan, e_gap, e_hdr;
    logic              dup_alloc, unexp_free;
    logic [ERR_N-1:0]  err_now;

    rsp_framer #(
        .TAG_W  (TAG_W),
        .CMD_W  (CMD_W),
        .SIZE_W (SIZE_W),
        .BCNT_W (BCNT_W)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsp_vld    (rsp_vld),
        .rsp_tag    (rsp_tag),
        .rsp_cmd    (rsp_cmd),
        .rsp_size   (rsp_size),
        .rsp_err    (rsp_err),
        .rsp_sop    (rsp_sop),
        .rsp_eop    (rsp_eop),
        .fwd        (fwd),
        .cmpl       (cmpl),
        .cmpl_tag   (cmpl_tag),
        .cmpl_cmd   (cmpl_cmd),
        .cmpl_err   (cmpl_err),
        .cmpl_beats (cmpl_beats),
        .e_len      (e_len),
        .e_nest     (e_nest),
        .e_orphan   (e_orphan),
        .e_gap      (e_gap),
        .e_hdr      (e_hdr)
    );

    rsp_tag_pool #(
        .TAG_W (TAG_W)
    ) u_pool (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_vld    (alloc_vld),
        .alloc_tag    (alloc_tag),
        .free_vld     (cmpl),
        .free_tag     (cmpl_tag),
        .dup_alloc    (dup_alloc),
        .unexp_free   (unexp_free),
        .inflight_cnt (inflight_cnt)
    );

    always_comb begin
        err_now             = '0;
        err_now[ERR_DUP]    = dup_alloc;
        err_now[ERR_UNEXP]  = unexp_free;
        err_now[ERR_NEST]   = e_nest;
        err_now[ERR_ORPHAN] = e_orphan;
        err_now[ERR_GAP]    = e_gap;
        err_now[ERR_HDR]    = e_hdr;
        err_now[ERR_LEN]    = e_len;

        o_d            = o_q;
        o_d.beat_vld   = fwd;
        o_d.done_vld   = cmpl;
        o_d.err        = o_q.err | err_now;
        if (fwd) begin
            o_d.beat_data = rsp_data;
        end
        if (cmpl) begin
            o_d.done_tag   = cmpl_tag;
            o_d.done_cmd   = cmpl_cmd;
            o_d.done_err   = cmpl_err;
            o_d.done_beats = cmpl_beats;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign beat_vld   = o_q.beat_vld;
    assign beat_data  = o_q.beat_data;
    assign done_vld   = o_q.done_vld;
    assign done_tag   = o_q.done_tag;
    assign done_cmd   = o_q.done_cmd;
    assign done_err   = o_q.done_err;
    assign done_beats = o_q.done_beats;
    assign err_flags  = o_q.err;

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(o_q.err) & ~o_q.err) == '0));                            // R13

    AST_DONE_BEATS_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.done_vld |-> (o_q.done_beats != '0));                        // R4

    AST_ORPHAN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        e_orphan |=> !o_q.beat_vld);                                     // R8

endmodule

// File: tb/sim_rsp_sink_top.sv
module sim_rsp_sink_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         alloc_vld;
    logic [8:0]   alloc_tag;
    logic         rsp_vld;
    logic [8:0]   rsp_tag;
    logic [5:0]   rsp_cmd;
    logic [2:0]   rsp_size;
    logic [255:0] rsp_data;
    logic         rsp_err;
    logic         rsp_sop;
    logic         rsp_eop;
    logic         beat_vld;
    logic [255:0] beat_data;
    logic         done_vld;
    logic [8:0]   done_tag;
    logic [5:0]   done_cmd;
    logic         done_err;
    logic [3:0]   done_beats;
    logic [9:0]   inflight_cnt;
    logic [6:0]   err_flags;

    int nchk  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    rsp_sink_top u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
        .rsp_vld(rsp_vld), .rsp_tag(rsp_tag), .rsp_cmd(rsp_cmd),
        .rsp_size(rsp_size), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .rsp_sop(rsp_sop), .rsp_eop(rsp_eop),
        .beat_vld(beat_vld), .beat_data(beat_data),
        .done_vld(done_vld), .done_tag(done_tag), .done_cmd(done_cmd),
        .done_err(done_err), .done_beats(done_beats),
        .inflight_cnt(inflight_cnt), .err_flags(err_flags)
    );

    // entry: tag[15:7], cmd[6:1], err[0]
    localparam logic [15:0] VEC [6] = '{
        {9'd17,  6'd1,  1'b0},
        {9'd0,   6'd63, 1'b1},
        {9'd511, 6'd7,  1'b0},
        {9'd256, 6'd32, 1'b1},
        {9'd85,  6'd21, 1'b0},
        {9'd170, 6'd42, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_in();
        alloc_vld = 1'b0; alloc_tag = '0;
        rsp_vld = 1'b0; rsp_tag = '0; rsp_cmd = '0; rsp_size = '0;
        rsp_data = '0; rsp_err = 1'b0; rsp_sop = 1'b0; rsp_eop = 1'b0;
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic alloc(input logic [8:0] t);
        alloc_vld = 1'b1; alloc_tag = t;
        tick();
        alloc_vld = 1'b0;
    endtask

    task automatic beat(input logic [8:0] t, input logic [5:0] c, input logic [2:0] sz,
                        input logic e, input logic s, input logic f, input logic [63:0] d);
        rsp_vld = 1'b1; rsp_tag = t; rsp_cmd = c; rsp_size = sz;
        rsp_err = e; rsp_sop = s; rsp_eop = f; rsp_data = {4{d}};
        tick();
        rsp_vld = 1'b0; rsp_sop = 1'b0; rsp_eop = 1'b0; rsp_err = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        idle_in();
        rst_n = 1'b0;
        tick();
        do_reset();
        // R1 reset state
        chk("R1 flags", 64'(err_flags), 64'h0);
        chk("R1 inflight", 64'(inflight_cnt), 64'h0);
        chk("R1 done_vld", 64'(done_vld), 64'h0);
        chk("R1 beat_vld", 64'(beat_vld), 64'h0);

        // table walk: allocate, then single-beat completion (R2, R4, R11 size 0)
        for (int i = 0; i < 6; i++) begin
            alloc(VEC[i][15:7]);
            chk("R2 inflight after alloc", 64'(inflight_cnt), 64'h1);
            beat(VEC[i][15:7], VEC[i][6:1], 3'd0, VEC[i][0], 1'b1, 1'b1, 64'(i) + 64'hA5);
            chk("R4 done_vld", 64'(done_vld), 64'h1);
            chk("R4 done_tag", 64'(done_tag), 64'(VEC[i][15:7]));
            chk("R4 done_cmd", 64'(done_cmd), 64'(VEC[i][6:1]));
            chk("R4 done_err", 64'(done_err), 64'(VEC[i][0]));
            chk("R4 done_beats", 64'(done_beats), 64'h1);
            chk("R4 beat_data", 64'(beat_data == {4{64'(i) + 64'hA5}}), 64'h1);
            chk("R4 freed", 64'(inflight_cnt), 64'h0);
            chk("R11 no error size0", 64'(err_flags), 64'h0);
            tick();
            chk("R4 pulse one cycle", 64'(done_vld), 64'h0);
        end

        // R3 duplicate allocate
        do_reset();
        alloc(9'd5);
        alloc(9'd5);
        chk("R3 dup flag", 64'(err_flags[0]), 64'h1);
        chk("R3 count held", 64'(inflight_cnt), 64'h1);

        // R5 four-beat response
        do_reset();
        alloc(9'd9);
        for (int b = 0; b < 4; b++) begin
            beat(9'd9, 6'd12, 3'd4, (b == 2), (b == 0), (b == 3), 64'(b) + 64'h100);
            chk("R5 beat_vld", 64'(beat_vld), 64'h1);
            chk("R5 beat_data", 64'(beat_data == {4{64'(b) + 64'h100}}), 64'h1);
            chk("R5 done timing", 64'(done_vld), 64'(b == 3));
        end
        chk("R5 beats", 64'(done_beats), 64'h4);
        chk("R5 err or", 64'(done_err), 64'h1);
        chk("R5 freed", 64'(inflight_cnt), 64'h0);
        chk("R5 no flags", 64'(err_flags), 64'h0);

        // R11 length mismatch
        do_reset();
        alloc(9'd3);
        beat(9'd3, 6'd2, 3'd3, 1'b0, 1'b1, 1'b0, 64'h1);
        beat(9'd3, 6'd2, 3'd3, 1'b0, 1'b0, 1'b1, 64'h2);
        chk("R11 len flag", 64'(err_flags), 64'h40);
        chk("R11 beats", 64'(done_beats), 64'h2);

        // R6 unexpected tag
        do_reset();
        beat(9'd7, 6'd4, 3'd0, 1'b0, 1'b1, 1'b1, 64'h3);
        chk("R6 unexp flag", 64'(err_flags), 64'h2);
        chk("R6 still done", 64'(done_vld), 64'h1);
        chk("R6 count", 64'(inflight_cnt), 64'h0);

        // R7 nested start
        do_reset();
        alloc(9'd1);
        alloc(9'd2);
        beat(9'd1, 6'd5, 3'd2, 1'b0, 1'b1, 1'b0, 64'h4);
        beat(9'd2, 6'd6, 3'd0, 1'b0, 1'b1, 1'b1, 64'h5);
        chk("R7 nest flag", 64'(err_flags), 64'h4);
        chk("R7 new tag done", 64'(done_tag), 64'h2);
        chk("R7 old tag kept", 64'(inflight_cnt), 64'h1);

        // R8 orphan beat
        do_reset();
        beat(9'd4, 6'd1, 3'd0, 1'b0, 1'b0, 1'b1, 64'h6);
        chk("R8 orphan flag", 64'(err_flags), 64'h8);
        chk("R8 not forwarded", 64'(beat_vld), 64'h0);
        chk("R8 no done", 64'(done_vld), 64'h0);

        // R9 valid gap
        do_reset();
        alloc(9'd4);
        beat(9'd4, 6'd1, 3'd2, 1'b0, 1'b1, 1'b0, 64'h7);
        tick();
        chk("R9 gap flag", 64'(err_flags), 64'h10);
        chk("R9 no done", 64'(done_vld), 64'h0);
        chk("R9 tag kept", 64'(inflight_cnt), 64'h1);

        // R10 header change
        do_reset();
        alloc(9'd6);
        beat(9'd6, 6'd10, 3'd2, 1'b0, 1'b1, 1'b0, 64'h8);
        beat(9'd6, 6'd11, 3'd2, 1'b0, 1'b0, 1'b1, 64'h9);
        chk("R10 hdr flag", 64'(err_flags), 64'h20);
        chk("R10 start cmd", 64'(done_cmd), 64'd10);

        // R12 same-cycle alloc and completion
        do_reset();
        alloc(9'd8);
        alloc_vld = 1'b1; alloc_tag = 9'd8;
        beat(9'd8, 6'd3, 3'd0, 1'b0, 1'b1, 1'b1, 64'hA);
        alloc_vld = 1'b0;
        chk("R12 no flag", 64'(err_flags), 64'h0);
        chk("R12 count", 64'(inflight_cnt), 64'h1);
        beat(9'd8, 6'd3, 3'd0, 1'b0, 1'b1, 1'b1, 64'hB);
        chk("R12 tag was live", 64'(err_flags[1]), 64'h0);

        // R13 sticky
        do_reset();
        beat(9'd9, 6'd1, 3'd0, 1'b0, 1'b0, 1'b0, 64'hC);
        repeat (4) tick();
        chk("R13 sticky", 64'(err_flags), 64'h8);
        do_reset();
        chk("R13 cleared by reset", 64'(err_flags), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule